// File: doc/BRIEF.md
# Four-Group Voice Channel Control Register Bank

This block holds the host-visible configuration for four groups of dual-channel voice processors, each group serving a channel A and a channel B. Each group owns a small window of per-channel registers and one main control byte. The main control byte sets the group's PCM coding (ITU-T versus sign-magnitude, A-law versus mu-law), its two tone-interrupt masks and its power state. Group 0's control byte also carries three bits that apply to the whole chip: a broadcast-write bit, an output-data enable, and a global interrupt mask. With broadcast enabled, a single host write into group 0's window lands at the same offset in every group.

Each group runs a state machine with the states `ST_OFF`, `ST_INIT1`, `ST_INIT2` and `ST_RUN`. The transitions are:

- *power-on*: `ST_OFF` to `ST_INIT1` when the power-up bit is 1. This also wipes the window.
- *first-frame*: `ST_INIT1` to `ST_INIT2` on a frame strobe.
- *second-frame*: `ST_INIT2` to `ST_RUN` on a frame strobe.
- *abort*: `ST_INIT1` or `ST_INIT2` to `ST_OFF` when the power-up bit is 0.
- *power-off*: `ST_RUN` to `ST_OFF` when the power-up bit is 0.

While a group is initialising, it ignores writes to its window and reports busy. While a group is powered down, its receive and send samples bypass the processor through a delay line that advances on each frame strobe. The processing itself is outside this block. Its outputs and its tone status enter as stub inputs.

Top module: `vpu_ctrl_bank`

## Requirements
- R1: After reset, every register reads 0x00, `out_en` is 0, `irq_n` is 1 and every group is powered down.
- R2: Group g's window register at offset k (k below 8) sits at address 0x040*g + k. Group g's main control byte sits at 0x400 + g. Window offsets 8 to 0x3F read 0x00 and ignore writes.
- R3: The main control byte uses these bits: bit 7 broadcast, bit 6 output enable, bit 5 global mask, bit 4 channel-B mask, bit 3 channel-A mask, bit 2 ITU-T select, bit 1 A-law select, bit 0 power-up. Bits 7 to 5 exist only in group 0. In groups 1 to 3 they read 0.
- R4: When broadcast (0x400 bit 7) is 1, a write to 0x000+k updates offset k in all four groups. Reads of any window still return that group's own contents.
- R5: When broadcast is 0, a window write changes only the addressed group. With broadcast at 1, writes to the windows of groups 1 to 3 still stay local.
- R6: `out_en` is 1 exactly when 0x400 bit 6 and `ode_pin` are both 1.
- R7: `irq_n` is 0 exactly when 0x400 bit 5 is 0 and some group has (`tone_a` and not its bit 3) or (`tone_b` and not its bit 4).
- R8: `fmt_itu[g]` follows bit 2 of group g's control byte, and `law_alaw[g]` follows bit 1.
- R9: With power-up 0, the output lanes show the input lanes as they stood two frame strobes earlier, and they hold still between strobes. With power-up 1, they show `ec_rout`/`ec_sout`.
- R10: A 0-to-1 change of power-up raises `grp_busy` and clears the group's window. Window writes are ignored until the second frame strobe after that, and `grp_busy` then falls.
- R11: Clearing power-up during initialisation drops `grp_busy` on the next clock edge and returns the group to the powered-down state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 11 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Combinational read data for `host_addr` |
| frame_strobe | input | 1 | One-cycle frame marker |
| ode_pin | input | 1 | External output enable |
| tone_a | input | 4 | Channel-A tone status per group |
| tone_b | input | 4 | Channel-B tone status per group |
| rin_flat | input | 32 | Receive-in samples, group g at [8g+7:8g] |
| sin_flat | input | 32 | Send-in samples, same layout |
| ec_rout | input | 32 | Processed receive samples from the processor stub |
| ec_sout | input | 32 | Processed send samples from the processor stub |
| rout_flat | output | 32 | Receive-out samples |
| sout_flat | output | 32 | Send-out samples |
| out_en | output | 1 | Drive enable for both serial outputs |
| irq_n | output | 1 | Tone interrupt, active low |
| law_alaw | output | 4 | Per-group A-law select |
| fmt_itu | output | 4 | Per-group ITU-T coding select |
| grp_busy | output | 4 | Per-group initialisation in progress |

## Verification
A group state machine stuck in an init state shows up at `grp_busy` right away, and at the next readback as a window that refuses writes. One that leaves init early lets a write land before the second strobe, so the read that follows returns the value. A wrongly stepped delay line moves `rout_flat` between strobes, or shows a sample one strobe early or late, which is visible at the strobe after it. Decode faults in broadcast or in masking of the global bits appear on the very next read of a neighbouring group or of a control byte.

// File: rtl/vpu_pkg.sv
package vpu_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_INIT1 = 2'd1,
        ST_INIT2 = 2'd2,
        ST_RUN   = 2'd3
    } grp_state_e;

    // control byte bit positions
    localparam int BIT_PWUP  = 0;
    localparam int BIT_LAW   = 1;
    localparam int BIT_FMT   = 2;
    localparam int BIT_MASKA = 3;
    localparam int BIT_MASKB = 4;
    localparam int BIT_GMASK = 5;
    localparam int BIT_ODE   = 6;
    localparam int BIT_BCAST = 7;

endpackage

// File: rtl/vpu_addr_dec.sv
module vpu_addr_dec #(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 11,
    parameter int WIN_OFF_W  = 6,
    parameter int MAIN_BASE  = 'h400
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  we,
    input  logic                  bcast,
    output logic [WIN_OFF_W-1:0]  off,
    output logic [NUM_GROUPS-1:0] win_sel,
    output logic [NUM_GROUPS-1:0] win_we,
    output logic [NUM_GROUPS-1:0] main_sel,
    output logic [NUM_GROUPS-1:0] main_we
);
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int HI_LO = WIN_OFF_W + GRP_W;

    logic in_win_region;

    assign off           = addr[WIN_OFF_W-1:0];
    assign in_win_region = (addr[ADDR_W-1:HI_LO] == '0);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
        assign win_sel[g]  = in_win_region && (addr[WIN_OFF_W +: GRP_W] == GRP_W'(g));
        assign main_sel[g] = (addr == ADDR_W'(MAIN_BASE + g));
        assign main_we[g]  = we && main_sel[g];
    end

    // broadcast mirrors the group-0 window onto every group
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_wr
        assign win_we[g] = we && (win_sel[g] || (bcast && win_sel[0]));
    end

endmodule

// File: rtl/vpu_grp_ctrl.sv
module vpu_grp_ctrl
    import vpu_pkg::*;
#(
    parameter bit HAS_GLOBAL = 1'b0,
    parameter int REG_W      = 8,
    parameter int WIN_REGS   = 8,
    parameter int WIN_OFF_W  = 6,
    parameter int SAMPLE_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_strobe,
    input  logic                 win_we,
    input  logic                 main_we,
    input  logic [WIN_OFF_W-1:0] off,
    input  logic [REG_W-1:0]     wdata,
    input  logic [SAMPLE_W-1:0]  rin,
    input  logic [SAMPLE_W-1:0]  sin,
    input  logic [SAMPLE_W-1:0]  ec_rout,
    input  logic [SAMPLE_W-1:0]  ec_sout,
    output logic [REG_W-1:0]     ctrl_q,
    output logic [REG_W-1:0]     win_rdata,
    output logic                 busy,
    output logic [SAMPLE_W-1:0]  rout,
    output logic [SAMPLE_W-1:0]  sout
);
    localparam logic [REG_W-1:0] LOCAL_MASK = REG_W'((1 << BIT_GMASK) - 1);
    localparam logic [REG_W-1:0] WR_MASK    = HAS_GLOBAL ? {REG_W{1'b1}} : LOCAL_MASK;

    grp_state_e          state_q, state_d;
    logic                pwup;
    logic                clear_win;
    logic [REG_W-1:0]    win_q [WIN_REGS];
    logic [SAMPLE_W-1:0] r_d1, r_d2, s_d1, s_d2;

    assign pwup = ctrl_q[BIT_PWUP];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state and state outputs
    always_comb begin
        state_d   = state_q;
        busy      = 1'b0;
        clear_win = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                busy = pwup;
                if (pwup) begin
                    clear_win = 1'b1;
                    state_d   = ST_INIT1;
                end
            end
            ST_INIT1: begin
                busy = 1'b1;
                if (!pwup)             state_d = ST_OFF;
                else if (frame_strobe) state_d = ST_INIT2;
            end
            ST_INIT2: begin
                busy = 1'b1;
                if (!pwup)             state_d = ST_OFF;
                else if (frame_strobe) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!pwup) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (main_we) ctrl_q <= wdata & WR_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_REGS; i++) win_q[i] <= '0;
        end else if (clear_win) begin
            for (int i = 0; i < WIN_REGS; i++) win_q[i] <= '0;
        end else if (win_we && !busy) begin
            for (int i = 0; i < WIN_REGS; i++)
                if (off == WIN_OFF_W'(i)) win_q[i] <= wdata;
        end
    end

    always_comb begin
        win_rdata = '0;
        for (int i = 0; i < WIN_REGS; i++)
            if (off == WIN_OFF_W'(i)) win_rdata = win_q[i];
    end

    // two-frame bypass line, advanced by every frame strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_d1 <= '0; r_d2 <= '0; s_d1 <= '0; s_d2 <= '0;
        end else if (frame_strobe) begin
            r_d1 <= rin; r_d2 <= r_d1;
            s_d1 <= sin; s_d2 <= s_d1;
        end
    end

    assign rout = pwup ? ec_rout : r_d2;
    assign sout = pwup ? ec_sout : s_d2;

endmodule

// File: rtl/vpu_ctrl_bank.sv
module vpu_ctrl_bank
    import vpu_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 11,
    parameter int REG_W      = 8,
    parameter int SAMPLE_W   = 8,
    parameter int WIN_REGS   = 8,
    parameter int WIN_OFF_W  = 6,
    parameter int MAIN_BASE  = 'h400
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           host_we,
    input  logic [ADDR_W-1:0]              host_addr,
    input  logic [REG_W-1:0]               host_wdata,
    output logic [REG_W-1:0]               host_rdata,
    input  logic                           frame_strobe,
    input  logic                           ode_pin,
    input  logic [NUM_GROUPS-1:0]          tone_a,
    input  logic [NUM_GROUPS-1:0]          tone_b,
    input  logic [NUM_GROUPS*SAMPLE_W-1:0] rin_flat,
    input  logic [NUM_GROUPS*SAMPLE_W-1:0] sin_flat,
    input  logic [NUM_GROUPS*SAMPLE_W-1:0] ec_rout,
    input  logic [NUM_GROUPS*SAMPLE_W-1:0] ec_sout,
    output logic [NUM_GROUPS*SAMPLE_W-1:0] rout_flat,
    output logic [NUM_GROUPS*SAMPLE_W-1:0] sout_flat,
    output logic                           out_en,
    output logic                           irq_n,
    output logic [NUM_GROUPS-1:0]          law_alaw,
    output logic [NUM_GROUPS-1:0]          fmt_itu,
    output logic [NUM_GROUPS-1:0]          grp_busy
);
    logic [WIN_OFF_W-1:0]  off;
    logic [NUM_GROUPS-1:0] win_sel, win_we, main_sel, main_we;
    logic [REG_W-1:0]      ctrl_q    [NUM_GROUPS];
    logic [REG_W-1:0]      win_rdata [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] pwup_vec, mask_a, mask_b;
    logic                  bcast_bit, ode_bit, gmask_bit;
    logic                  tone_any;

    assign bcast_bit = ctrl_q[0][BIT_BCAST];
    assign ode_bit   = ctrl_q[0][BIT_ODE];
    assign gmask_bit = ctrl_q[0][BIT_GMASK];

    vpu_addr_dec #(
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W),
        .WIN_OFF_W  (WIN_OFF_W),
        .MAIN_BASE  (MAIN_BASE)
    ) u_dec (
        .addr     (host_addr),
        .we       (host_we),
        .bcast    (bcast_bit),
        .off      (off),
        .win_sel  (win_sel),
        .win_we   (win_we),
        .main_sel (main_sel),
        .main_we  (main_we)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        vpu_grp_ctrl #(
            .HAS_GLOBAL (g == 0),
            .REG_W      (REG_W),
            .WIN_REGS   (WIN_REGS),
            .WIN_OFF_W  (WIN_OFF_W),
            .SAMPLE_W   (SAMPLE_W)
        ) u_grp (
            .clk          (clk),
            .rst_n        (rst_n),
            .frame_strobe (frame_strobe),
            .win_we       (win_we[g]),
            .main_we      (main_we[g]),
            .off          (off),
            .wdata        (host_wdata),
            .rin          (rin_flat[g*SAMPLE_W +: SAMPLE_W]),
            .sin          (sin_flat[g*SAMPLE_W +: SAMPLE_W]),
            .ec_rout      (ec_rout[g*SAMPLE_W +: SAMPLE_W]),
            .ec_sout      (ec_sout[g*SAMPLE_W +: SAMPLE_W]),
            .ctrl_q       (ctrl_q[g]),
            .win_rdata    (win_rdata[g]),
            .busy         (grp_busy[g]),
            .rout         (rout_flat[g*SAMPLE_W +: SAMPLE_W]),
            .sout         (sout_flat[g*SAMPLE_W +: SAMPLE_W])
        );
        assign pwup_vec[g] = ctrl_q[g][BIT_PWUP];
        assign mask_a[g]   = ctrl_q[g][BIT_MASKA];
        assign mask_b[g]   = ctrl_q[g][BIT_MASKB];
        assign law_alaw[g] = ctrl_q[g][BIT_LAW];
        assign fmt_itu[g]  = ctrl_q[g][BIT_FMT];
    end

    always_comb begin
        host_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (win_sel[g])  host_rdata = win_rdata[g];
            if (main_sel[g]) host_rdata = ctrl_q[g];
        end
    end

    assign tone_any = |((tone_a & ~mask_a) | (tone_b & ~mask_b));
    assign irq_n    = ~(tone_any & ~gmask_bit);
    assign out_en   = ode_bit & ode_pin;

endmodule

// File: rtl/vpu_ctrl_chk.sv
module vpu_ctrl_chk #(
    parameter int NUM_GROUPS = 4,
    parameter int SAMPLE_W   = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           host_we,
    input logic                           frame_strobe,
    input logic                           ode_pin,
    input logic                           out_en,
    input logic                           irq_n,
    input logic                           gmask,
    input logic [NUM_GROUPS-1:0]          pwup,
    input logic [NUM_GROUPS-1:0]          busy,
    input logic [NUM_GROUPS*SAMPLE_W-1:0] rout_flat
);
    // R6
    oe_pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ode_pin |-> !out_en);

    // R7
    irq_gmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gmask |-> irq_n);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        // R10
        init_end_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(busy[g]) && pwup[g]) |-> $past(frame_strobe));

        // R11
        abort_drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pwup[g] && !host_we) |=> !busy[g]);

        // R9
        bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pwup[g] && !$past(pwup[g]) && !$past(frame_strobe))
                |-> $stable(rout_flat[g*SAMPLE_W +: SAMPLE_W]));
    end

endmodule

bind vpu_ctrl_bank vpu_ctrl_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .SAMPLE_W   (SAMPLE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we      (host_we),
    .frame_strobe (frame_strobe),
    .ode_pin      (ode_pin),
    .out_en       (out_en),
    .irq_n        (irq_n),
    .gmask        (gmask_bit),
    .pwup         (pwup_vec),
    .busy         (grp_busy),
    .rout_flat    (rout_flat)
);

// File: tb/test_vpu_ctrl_bank.sv
module test_vpu_ctrl_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [10:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        frame_strobe = 1'b0;
    logic        ode_pin = 1'b0;
    logic [3:0]  tone_a = '0, tone_b = '0;
    logic [31:0] rin_flat = '0, sin_flat = '0;
    logic [31:0] ec_rout = 32'hD3C2B1A0, ec_sout = 32'h4C3D2E1F;
    logic [31:0] rout_flat, sout_flat;
    logic        out_en, irq_n;
    logic [3:0]  law_alaw, fmt_itu, grp_busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    vpu_ctrl_bank i_vpu_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .frame_strobe(frame_strobe),
        .ode_pin(ode_pin), .tone_a(tone_a), .tone_b(tone_b), .rin_flat(rin_flat),
        .sin_flat(sin_flat), .ec_rout(ec_rout), .ec_sout(ec_sout), .rout_flat(rout_flat),
        .sout_flat(sout_flat), .out_en(out_en), .irq_n(irq_n), .law_alaw(law_alaw),
        .fmt_itu(fmt_itu), .grp_busy(grp_busy)
    );

    // {req, we, addr, wdata, expected read}
    localparam int NVEC = 22;
    localparam logic [39:0] VEC [NVEC] = '{
        40'h05_1_001_11_00, // R5 write g0 off1
        40'h05_1_041_22_00, // R5 write g1 off1
        40'h02_0_001_00_11, // R2 readback g0
        40'h02_0_041_00_22, // R2 readback g1
        40'h05_0_081_00_00, // R5 g2 untouched
        40'h02_1_03F_55_00, // R2 write unimplemented offset
        40'h02_0_03F_00_00, // R2 reads zero
        40'h03_1_401_E6_00, // R3 global bits in g1 dropped
        40'h03_0_401_00_06, // R3
        40'h04_1_400_80_00, // R4 broadcast on
        40'h03_0_400_00_80, // R3 g0 keeps bit 7
        40'h04_1_002_5A_00, // R4 broadcast write
        40'h04_0_002_00_5A, // R4
        40'h04_0_042_00_5A, // R4
        40'h04_0_082_00_5A, // R4
        40'h04_0_0C2_00_5A, // R4
        40'h05_1_043_77_00, // R5 g1 write stays local
        40'h05_0_003_00_00, // R5
        40'h05_0_043_00_77, // R5
        40'h04_1_001_99_00, // R4 overwrite all
        40'h04_0_041_00_99, // R4 own read of g1
        40'h04_1_400_00_00  // R4 broadcast off
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic frame_pulse();
        @(negedge clk);
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        #1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 out_en", {31'd0, out_en}, 32'd0);
        check("R1 irq_n", {31'd0, irq_n}, 32'd1);
        check("R1 rout", rout_flat, 32'd0);
        host_read(11'h400, rd); check("R1 ctrl0", {24'd0, rd}, 32'd0);
        host_read(11'h0C0, rd); check("R1 win3", {24'd0, rd}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][31:28] != 4'd0) begin
                host_write(VEC[i][26:16], VEC[i][15:8]);
            end else begin
                host_read(VEC[i][26:16], rd);
                check($sformatf("R%0d vec%0d", VEC[i][39:32], i), {24'd0, rd}, {24'd0, VEC[i][7:0]});
            end
        end

        // R8 coding selects follow group 1's byte 0x06
        check("R8 law", {28'd0, law_alaw}, 32'h2);
        check("R8 fmt", {28'd0, fmt_itu}, 32'h2);

        // R6 output enable gating
        host_write(11'h400, 8'h40);
        #1 check("R6 pin low", {31'd0, out_en}, 32'd0);
        ode_pin = 1'b1; #1 check("R6 both high", {31'd0, out_en}, 32'd1);
        host_write(11'h400, 8'h00);
        #1 check("R6 bit low", {31'd0, out_en}, 32'd0);

        // R7 interrupt masking
        tone_a = 4'b0100; #1 check("R7 raw tone", {31'd0, irq_n}, 32'd0);
        host_write(11'h402, 8'h08);
        #1 check("R7 chan A mask", {31'd0, irq_n}, 32'd1);
        tone_b = 4'b0100; #1 check("R7 chan B live", {31'd0, irq_n}, 32'd0);
        host_write(11'h400, 8'h20);
        #1 check("R7 global mask", {31'd0, irq_n}, 32'd1);
        host_write(11'h400, 8'h00);
        host_write(11'h402, 8'h00);
        tone_a = '0; tone_b = '0;
        #1 check("R7 idle", {31'd0, irq_n}, 32'd1);

        // R9 two-frame bypass
        rin_flat = 32'h13121110; sin_flat = ~32'h13121110;
        frame_pulse();
        check("R9 after 1 strobe", rout_flat, 32'd0);
        rin_flat = 32'h23222120; sin_flat = ~32'h23222120;
        frame_pulse();
        check("R9 after 2 strobes", rout_flat, 32'h13121110);
        check("R9 send lane", sout_flat, ~32'h13121110);
        rin_flat = 32'h33323130;
        repeat (3) @(negedge clk);
        #1 check("R9 hold between strobes", rout_flat, 32'h13121110);
        frame_pulse();
        check("R9 after 3 strobes", rout_flat, 32'h23222120);

        // R10 initialisation on group 0
        host_write(11'h000, 8'h33);
        host_write(11'h400, 8'h01);
        #1 check("R10 busy raised", {28'd0, grp_busy}, 32'h1);
        host_read(11'h000, rd); check("R10 window cleared", {24'd0, rd}, 32'd0);
        host_write(11'h000, 8'h44);
        host_read(11'h000, rd); check("R10 write ignored", {24'd0, rd}, 32'd0);
        frame_pulse();
        check("R10 busy after 1 strobe", {28'd0, grp_busy}, 32'h1);
        frame_pulse();
        check("R10 busy after 2 strobes", {28'd0, grp_busy}, 32'h0);
        host_write(11'h000, 8'h44);
        host_read(11'h000, rd); check("R10 write accepted", {24'd0, rd}, 32'h44);
        check("R9 active lane", {24'd0, rout_flat[7:0]}, 32'hA0);

        // R11 abort during init on group 1
        host_write(11'h401, 8'h01);
        #1 check("R11 busy raised", {31'd0, grp_busy[1]}, 32'd1);
        frame_pulse();
        host_write(11'h401, 8'h00);
        @(negedge clk);
        #1 check("R11 busy dropped", {31'd0, grp_busy[1]}, 32'd0);
        check("R11 bypass resumed", {24'd0, rout_flat[15:8]}, 32'h31);

        summary();
        $finish;
    end

endmodule